// File: doc/BRIEF.md
# Radix-4 Iterative Divider

This block is a sequential integer divider that retires two quotient bits on every clock. It accepts either a narrow dividend of one data word or a wide dividend formed from a high word and a low word, and divides it by a one-word divisor. Both unsigned and two's-complement signed operation are supported. The quotient is delivered on one output register and the remainder on its coupled partner.

An accepted start is followed by a single setup cycle that takes operand magnitudes, rejects a zero divisor and spots a quotient too large for one word. Eight radix-4 iteration cycles then develop the sixteen quotient bits, and a final cycle restores signs and range-checks the result. The whole operation takes ten cycles. An abort input lets an interrupt cancel the divide at any point. The caller must then reissue it from scratch.

Top module: `radix4_divider`

## Requirements
- R1: A start seen while idle raises busy on the next cycle. A normal operation keeps busy high for exactly 10 cycles (1 setup, 8 iterations, 1 correction). Done pulses in the cycle after the last busy cycle.
- R2: Unsigned mode (sgn_mode=0) yields quotient = floor(dividend/divisor) and remainder = dividend mod divisor.
- R3: Signed mode (sgn_mode=1) truncates the quotient toward zero. The remainder carries the sign of the dividend.
- R4: With wide_mode=1 the dividend is the 32-bit value {dvd_hi, dvd_lo}. With wide_mode=0 dvd_hi is ignored: dvd_lo alone is the dividend, sign-extended in signed mode.
- R5: A zero divisor sets div_zero. Busy lasts one cycle and done pulses after it. Quotient and remainder keep their previous values.
- R6: A quotient outside the result range (0..65535 unsigned, -32768..32767 signed) sets overflow and leaves quotient and remainder unchanged. When the dividend's high-word magnitude is at least the divisor magnitude, the unit ends after the setup cycle like R5. Otherwise it ends at the normal R1 time.
- R7: Abort while busy returns the unit to idle on the next cycle, with no done pulse and no change to the outputs. Abort while idle has no effect.
- R8: Start asserted while busy is ignored: operands are not reloaded and the running operation finishes with its original result and timing.
- R9: div_zero and overflow are cleared when a start is accepted and are otherwise held. They are never both high.
- R10: Synchronous reset clears quotient, remainder, busy, done, div_zero and overflow to zero.
- R11: Done is a single-cycle pulse and is never high together with busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a divide when idle |
| sgn_mode | input | 1 | 1 = signed operands and results |
| wide_mode | input | 1 | 1 = dividend is {dvd_hi, dvd_lo} |
| abort | input | 1 | Cancel a running divide |
| dvd_hi | input | 16 | High word of a wide dividend |
| dvd_lo | input | 16 | Low word of the dividend |
| divisor | input | 16 | Divisor |
| quotient | output | 16 | Quotient register |
| remainder | output | 16 | Remainder register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last operation had a zero divisor |
| overflow | output | 1 | Last quotient did not fit the result range |

## Verification
Directed operands cover every sign combination in both widths, so that truncation direction and remainder sign are separated from magnitude errors. Dividends near the range edges (0x8000 by -1, wide values whose high word meets or trails the divisor) separate early overflow from late overflow by the cycle in which done appears. Narrow operations carry junk in the high word to show it is ignored. A long random run mixes zero divisors, aborts at every phase and stray starts during busy, all against a behavioural model compared on every clock.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ITER  = 2'd2,
    ST_FIX   = 2'd3
  } div_state_e;
endpackage

// File: rtl/div_prep.sv
// Setup-cycle operand conditioning: magnitudes, sign flags, early exits.
module div_prep #(
  parameter int W = 16
) (
  input  logic [W-1:0]   hi_word,
  input  logic [W-1:0]   lo_word,
  input  logic [W-1:0]   dsr,
  input  logic           sgn,
  input  logic           wide,
  output logic [2*W-1:0] mag_dvd,
  output logic [W-1:0]   mag_dsr,
  output logic           neg_q,
  output logic           neg_r,
  output logic           dsr_zero,
  output logic           early_ovf
);
  localparam int DW = 2 * W;

  logic [DW-1:0] full_dvd;
  logic          dvd_neg;
  logic          dsr_neg;

  always_comb begin
    if (wide)
      full_dvd = {hi_word, lo_word};
    else if (sgn)
      full_dvd = {{W{lo_word[W-1]}}, lo_word};
    else
      full_dvd = {{W{1'b0}}, lo_word};
    dvd_neg   = sgn & full_dvd[DW-1];
    dsr_neg   = sgn & dsr[W-1];
    mag_dvd   = dvd_neg ? (~full_dvd + 1'b1) : full_dvd;
    mag_dsr   = dsr_neg ? (~dsr + 1'b1) : dsr;
    neg_r     = dvd_neg;
    neg_q     = dvd_neg ^ dsr_neg;
    dsr_zero  = (dsr == '0);
    early_ovf = (mag_dvd[DW-1:W] >= mag_dsr);
  end
endmodule

// File: rtl/div_r4_step.sv
// One radix-4 restoring step: compares the shifted partial remainder with 1x, 2x, 3x divisor.
module div_r4_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] rem_in,
  input  logic [1:0]   next_bits,
  input  logic [W-1:0] dsr,
  output logic [W-1:0] rem_out,
  output logic [1:0]   digit
);
  localparam int RW = W + 2;

  logic [RW-1:0]        r4;
  logic [3:1][RW-1:0]   mult;
  logic [3:1][RW:0]     diff;
  logic [3:1]           fits;

  assign r4 = {rem_in, next_bits};

  for (genvar k = 1; k < 4; k++) begin : g_mult
    localparam logic [1:0] KK = 2'(k);
    assign mult[k] = {2'b00, dsr} * {{W{1'b0}}, KK};
    assign diff[k] = {1'b0, r4} - {1'b0, mult[k]};
    assign fits[k] = ~diff[k][RW];
  end

  always_comb begin
    if (fits[3]) begin
      digit   = 2'd3;
      rem_out = diff[3][W-1:0];
    end else if (fits[2]) begin
      digit   = 2'd2;
      rem_out = diff[2][W-1:0];
    end else if (fits[1]) begin
      digit   = 2'd1;
      rem_out = diff[1][W-1:0];
    end else begin
      digit   = 2'd0;
      rem_out = r4[W-1:0];
    end
  end
endmodule

// File: rtl/div_fix.sv
// Correction cycle: restore signs and check the signed result range.
module div_fix #(
  parameter int W = 16
) (
  input  logic [W-1:0] q_mag,
  input  logic [W-1:0] r_mag,
  input  logic         neg_q,
  input  logic         neg_r,
  input  logic         sgn,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         range_ovf
);
  localparam logic [W-1:0] MIN_MAG = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    quo = neg_q ? (~q_mag + 1'b1) : q_mag;
    rem = neg_r ? (~r_mag + 1'b1) : r_mag;
    if (!sgn)
      range_ovf = 1'b0;
    else if (neg_q)
      range_ovf = (q_mag > MIN_MAG);
    else
      range_ovf = q_mag[W-1];
  end
endmodule

// File: rtl/radix4_divider.sv
module radix4_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         sgn_mode,
  input  logic         wide_mode,
  input  logic         abort,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         busy,
  output logic         done,
  output logic         div_zero,
  output logic         overflow
);
  import div_pkg::*;

  localparam int ITERS = W / 2;
  localparam int CW    = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

  div_state_e    state;
  logic [CW-1:0] cnt;
  logic [W-1:0]  op_hi, op_lo, op_dsr;
  logic          op_sgn, op_wide;
  logic [W-1:0]  r_acc, sh_lo, q_acc, d_mag;
  logic          neg_q_r, neg_r_r;
  logic          done_q, dz_q, ovf_q;
  logic [W-1:0]  quo_q, rem_q;

  logic [2*W-1:0] p_mag_dvd;
  logic [W-1:0]   p_mag_dsr;
  logic           p_neg_q, p_neg_r, p_zero, p_early;
  logic [W-1:0]   s_rem;
  logic [1:0]     s_digit;
  logic [W-1:0]   f_quo, f_rem;
  logic           f_ovf;

  div_prep #(.W(W)) prep_i (
    .hi_word  (op_hi),
    .lo_word  (op_lo),
    .dsr      (op_dsr),
    .sgn      (op_sgn),
    .wide     (op_wide),
    .mag_dvd  (p_mag_dvd),
    .mag_dsr  (p_mag_dsr),
    .neg_q    (p_neg_q),
    .neg_r    (p_neg_r),
    .dsr_zero (p_zero),
    .early_ovf(p_early)
  );

  div_r4_step #(.W(W)) step_i (
    .rem_in   (r_acc),
    .next_bits(sh_lo[W-1:W-2]),
    .dsr      (d_mag),
    .rem_out  (s_rem),
    .digit    (s_digit)
  );

  div_fix #(.W(W)) fix_i (
    .q_mag    (q_acc),
    .r_mag    (r_acc),
    .neg_q    (neg_q_r),
    .neg_r    (neg_r_r),
    .sgn      (op_sgn),
    .quo      (f_quo),
    .rem      (f_rem),
    .range_ovf(f_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      op_hi   <= '0;
      op_lo   <= '0;
      op_dsr  <= '0;
      op_sgn  <= 1'b0;
      op_wide <= 1'b0;
      r_acc   <= '0;
      sh_lo   <= '0;
      q_acc   <= '0;
      d_mag   <= '0;
      neg_q_r <= 1'b0;
      neg_r_r <= 1'b0;
      done_q  <= 1'b0;
      dz_q    <= 1'b0;
      ovf_q   <= 1'b0;
      quo_q   <= '0;
      rem_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            op_hi   <= dvd_hi;
            op_lo   <= dvd_lo;
            op_dsr  <= divisor;
            op_sgn  <= sgn_mode;
            op_wide <= wide_mode;
            dz_q    <= 1'b0;
            ovf_q   <= 1'b0;
            state   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (abort) begin
            state <= ST_IDLE;
          end else if (p_zero) begin
            dz_q   <= 1'b1;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else if (p_early) begin
            ovf_q  <= 1'b1;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            r_acc   <= p_mag_dvd[2*W-1:W];
            sh_lo   <= p_mag_dvd[W-1:0];
            q_acc   <= '0;
            d_mag   <= p_mag_dsr;
            neg_q_r <= p_neg_q;
            neg_r_r <= p_neg_r;
            cnt     <= '0;
            state   <= ST_ITER;
          end
        end
        ST_ITER: begin
          if (abort) begin
            state <= ST_IDLE;
          end else begin
            r_acc <= s_rem;
            sh_lo <= {sh_lo[W-3:0], 2'b00};
            q_acc <= {q_acc[W-3:0], s_digit};
            cnt   <= cnt + 1'b1;
            if (cnt == LAST) state <= ST_FIX;
          end
        end
        ST_FIX: begin
          if (abort) begin
            state <= ST_IDLE;
          end else begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
            if (f_ovf) begin
              ovf_q <= 1'b1;
            end else begin
              quo_q <= f_quo;
              rem_q <= f_rem;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign div_zero  = dz_q;
  assign overflow  = ovf_q;
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         abort,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         busy,
  input logic         done,
  input logic         div_zero,
  input logic         overflow
);
  localparam int MAXB = W / 2 + 2;

  logic        rst_q;
  logic [7:0]  bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_q <= 1'b1;
      bcnt  <= '0;
    end else begin
      rst_q <= 1'b0;
      bcnt  <= busy ? bcnt + 1'b1 : 8'd0;
    end
  end

  assert_busy_after_start_R1: assert property (@(posedge clk) disable iff (rst || rst_q)
    (!busy && start) |=> busy);

  assert_busy_len_R1: assert property (@(posedge clk) disable iff (rst || rst_q)
    busy |-> (bcnt < 8'(MAXB)));

  assert_dz_keeps_R5: assert property (@(posedge clk) disable iff (rst || rst_q)
    $rose(div_zero) |-> ($stable(quotient) && $stable(remainder)));

  assert_ovf_keeps_R6: assert property (@(posedge clk) disable iff (rst || rst_q)
    $rose(overflow) |-> ($stable(quotient) && $stable(remainder)));

  assert_abort_R7: assert property (@(posedge clk) disable iff (rst || rst_q)
    (busy && abort) |=> (!busy && !done));

  assert_result_on_done_R8: assert property (@(posedge clk) disable iff (rst || rst_q)
    (!$stable(quotient) || !$stable(remainder)) |-> done);

  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (rst || rst_q)
    !(div_zero && overflow));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst || rst_q)
    done |=> !done);

  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (rst || rst_q)
    done |-> !busy);
endmodule

bind radix4_divider div_checker #(.W(W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .abort    (abort),
  .quotient (quotient),
  .remainder(remainder),
  .busy     (busy),
  .done     (done),
  .div_zero (div_zero),
  .overflow (overflow)
);

// File: tb/radix4_divider_tb_top.sv
`timescale 1ns/1ps
module radix4_divider_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         sgn_mode = 1'b0;
  logic         wide_mode = 1'b0;
  logic         abort = 1'b0;
  logic [W-1:0] dvd_hi = '0;
  logic [W-1:0] dvd_lo = '0;
  logic [W-1:0] divisor = '0;
  logic [W-1:0] quotient, remainder;
  logic         busy, done, div_zero, overflow;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  radix4_divider #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .sgn_mode(sgn_mode), .wide_mode(wide_mode),
    .abort(abort), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
    .quotient(quotient), .remainder(remainder), .busy(busy), .done(done),
    .div_zero(div_zero), .overflow(overflow)
  );

  // Behavioural reference model, advanced on every rising edge.
  int          m_left = 0;
  logic [15:0] e_quo = '0, e_rem = '0;
  logic        e_busy = 0, e_done = 0, e_dz = 0, e_ovf = 0;
  logic        p_dz, p_early, p_ovf;
  logic [15:0] p_q, p_r;
  string       p_tag = "R2";
  string       m_note = "";

  always @(posedge clk) begin
    longint dd, ds, ad, ads, q, r;
    m_note = "";
    if (rst) begin
      m_left = 0; e_quo = '0; e_rem = '0; e_done = 0; e_dz = 0; e_ovf = 0;
      m_note = "/R10";
    end else begin
      e_done = 0;
      if (m_left == 0) begin
        if (abort) m_note = "/R7";
        if (start) begin
          if (wide_mode) dd = sgn_mode ? longint'($signed({dvd_hi, dvd_lo})) : longint'({dvd_hi, dvd_lo});
          else           dd = sgn_mode ? longint'($signed(dvd_lo)) : longint'(dvd_lo);
          ds = sgn_mode ? longint'($signed(divisor)) : longint'(divisor);
          p_tag = wide_mode ? "R4" : (sgn_mode ? "R3" : "R2");
          p_dz = (ds == 0); p_early = 0; p_ovf = 0; p_q = '0; p_r = '0;
          if (!p_dz) begin
            q = dd / ds; r = dd % ds;
            ad = (dd < 0) ? -dd : dd; ads = (ds < 0) ? -ds : ds;
            p_early = ((ad >> 16) >= ads);
            p_ovf = sgn_mode ? (q > 32767 || q < -32768) : (q > 65535);
            p_q = q[15:0]; p_r = r[15:0];
          end
          e_dz = 0; e_ovf = 0; m_left = 10; m_note = "/R9";
        end
      end else if (abort) begin
        m_left = 0; m_note = "/R7";
      end else if (m_left == 10 && (p_dz || p_early)) begin
        m_left = 0; e_done = 1;
        if (p_dz) begin e_dz = 1; m_note = "/R5"; end
        else begin e_ovf = 1; m_note = "/R6"; end
      end else begin
        if (start) m_note = "/R8";
        m_left = m_left - 1;
        if (m_left == 0) begin
          e_done = 1;
          if (p_ovf) begin e_ovf = 1; m_note = "/R6"; end
          else begin e_quo = p_q; e_rem = p_r; end
        end
      end
    end
    e_busy = (m_left != 0);
  end

  task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, nm, act, exp);
    end
  endtask

  // Compare every output on every falling edge.
  always @(negedge clk) begin
    cycles++;
    chk({"R1", m_note}, "busy", 32'(busy), 32'(e_busy));
    chk({"R11", m_note}, "done", 32'(done), 32'(e_done));
    chk({p_tag, m_note}, "quotient", 32'(quotient), 32'(e_quo));
    chk({p_tag, m_note}, "remainder", 32'(remainder), 32'(e_rem));
    chk({"R5", m_note}, "div_zero", 32'(div_zero), 32'(e_dz));
    chk({"R6", m_note}, "overflow", 32'(overflow), 32'(e_ovf));
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic run_op(logic [15:0] hi, logic [15:0] lo, logic [15:0] d, logic s, logic w);
    @(negedge clk);
    wait_idle();
    dvd_hi = hi; dvd_lo = lo; divisor = d; sgn_mode = s; wide_mode = w; start = 1;
    @(negedge clk);
    start = 0;
    wait_idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R2 unsigned
    run_op(16'h0000, 16'd100, 16'd7, 0, 0);
    run_op(16'h0000, 16'hFFFF, 16'd1, 0, 0);
    run_op(16'h0000, 16'd0, 16'd5, 0, 0);
    run_op(16'h0000, 16'hFFFF, 16'hFFFF, 0, 0);
    // R3 signed sign combinations
    run_op(16'h0000, 16'hFFF9, 16'd2, 1, 0);
    run_op(16'h0000, 16'd7, 16'hFFFE, 1, 0);
    run_op(16'h0000, 16'hFFF9, 16'hFFFE, 1, 0);
    // R6 late overflow in narrow signed mode
    run_op(16'h0000, 16'h8000, 16'hFFFF, 1, 0);
    // R5 zero divisor
    run_op(16'h0000, 16'd1234, 16'd0, 0, 0);
    // R4 wide dividend, and narrow mode with junk high word
    run_op(16'h0001, 16'h0000, 16'd2, 0, 1);
    run_op(16'h0002, 16'h0000, 16'd2, 0, 1);
    run_op(16'hFFFF, 16'h0000, 16'd2, 1, 1);
    run_op(16'h0000, 16'h8000, 16'd1, 1, 1);
    run_op(16'h1234, 16'h5678, 16'h9ABC, 0, 1);
    run_op(16'hABCD, 16'd1000, 16'd10, 0, 0);
    // R7 abort in setup, in iteration, and while idle
    @(negedge clk); dvd_lo = 16'd50; divisor = 16'd3; sgn_mode = 0; wide_mode = 0; start = 1;
    @(negedge clk); start = 0; abort = 1;
    @(negedge clk); abort = 0;
    repeat (2) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    start = 1; @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    wait_idle();
    // R8 start held high with new operands while busy
    @(negedge clk); dvd_lo = 16'd999; divisor = 16'd4; start = 1;
    @(negedge clk); dvd_lo = 16'd1; divisor = 16'd1;
    repeat (3) @(negedge clk);
    start = 0;
    wait_idle();
    repeat (2) @(negedge clk);
    // Random mix; R4: narrow operations carry random high words
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      dvd_hi = 16'($urandom); dvd_lo = 16'($urandom);
      if (($urandom % 3) == 0) dvd_hi = dvd_hi & 16'h00FF;
      case ($urandom % 5)
        0: divisor = 16'd0;
        1: divisor = 16'($urandom % 8);
        default: divisor = 16'($urandom);
      endcase
      sgn_mode = 1'($urandom); wide_mode = 1'($urandom); start = 1;
      @(negedge clk);
      start = 0;
      while (busy) begin
        start = (($urandom % 4) == 0);
        abort = (($urandom % 60) == 0);
        @(negedge clk);
      end
      start = 0; abort = 0;
    end
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule